// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Unit

This block is a multiply and multiply-accumulate engine that sits beside a processor's integer pipeline. Each clock it can take one operation: a valid strobe, a three-bit opcode, a width select and two 32-bit operands. It returns one result beat per operation exactly four clocks later. The unit holds one 48-bit accumulator, a sticky overflow flag and a three-bit mode word. The mode word chooses how operands are read (signed integer, unsigned integer or signed fraction) and whether accumulator overflow saturates or wraps.

Multiply-add and multiply-subtract update the accumulator. A plain multiply returns a 32-bit product and leaves the accumulator alone. Other opcodes write, clear or read the accumulator, and write or read the mode word. The accumulator is updated only in the last pipeline stage, so every accumulator operation takes effect in issue order. Back-to-back dependent accumulates never stall. A mode write takes effect for the very next issued operation.

Top module: `mac_unit`

## Requirements
- R1: Every operation accepted with `in_valid` high produces exactly one `out_valid` pulse four clock edges later. Operations may be issued on consecutive clocks, and results leave in issue order. No result appears without an issue.
- R2: Opcode 000 (multiply) returns the product in `out_data[31:0]`, with bits 47:32 zero. In integer formats this is the low 32 bits of the full product. In fractional format it is bits 63:32 of the doubled product. When `in_half` is 1 only bits 15:0 of each operand are used, sign-extended (signed format) or zero-extended (unsigned format).
- R3: Opcode 010 adds the product to the accumulator and opcode 011 subtracts it. Each returns the new accumulator value. Dependent operations on consecutive clocks each see the result of the previous one.
- R4: In fractional format (mode bits 1:0 = 10), operands are Q31 values. A half-width operand in bits 15:0 is a Q15 value placed in the top half. The product is doubled. The single case of minus one times minus one is clamped to the largest positive 64-bit value. Bits 63:16 of that value, sign-extended, are what is accumulated.
- R5: In signed and fractional formats, an accumulate result outside the 48-bit two's-complement range sets the sticky overflow flag `out_ovf`. With mode bit 2 = 0 the value wraps. With mode bit 2 = 1 it clamps to 0x7FFFFFFFFFFF or 0x800000000000. The flag stays set through later operations.
- R6: Opcode 100 loads the accumulator with {`in_b[15:0]`, `in_a`} and returns it. Opcode 101 clears the accumulator and the overflow flag and returns 0. Opcode 110 returns the accumulator. All of these take effect in issue order relative to accumulates already in flight.
- R7: Opcode 111 writes the mode word from `in_a[2:0]`. Bits 1:0 are the format: 00 signed, 01 unsigned, 10 fractional, 11 treated as signed. Bit 2 is the saturate enable. The new mode applies to the next issued operation. Opcodes 111 and 001 return {overflow flag, saturate, format} in bits 3:0, with all higher bits zero.
- R8: After reset the accumulator is 0, the mode word is 0 (signed, wrapping), the overflow flag is 0 and `out_valid` is 0.
- R9: In unsigned format the accumulator range is 0 to 0xFFFFFFFFFFFF. Leaving it sets the overflow flag. The value then wraps, or clamps to 0 (below the range) or 0xFFFFFFFFFFFF (above it) when saturation is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation issue strobe |
| in_op | input | 3 | Opcode |
| in_half | input | 1 | 1 selects 16x16 operands from bits 15:0 |
| in_a | input | 32 | First operand, or write data |
| in_b | input | 32 | Second operand, or upper write data |
| out_valid | output | 1 | Result beat strobe |
| out_data | output | 48 | Result value |
| out_ovf | output | 1 | Sticky accumulator overflow flag |

## Verification
The bench targets issue-order hazards:
- An accumulator load or clear placed directly after a multiply-add must win. A design that updated the accumulator out of order would return a stale sum.
- A mode write followed at once by a multiply must use the new format, or the product comes out sign-extended when it should not be.

The arithmetic corner cases are the fractional minus-one squared, the 48-bit signed and unsigned range edges in both wrap and saturate modes, and the 16-bit operand extension. A wrong design shows up as a wrapped value where a clamp was due, a missing or uncleared sticky flag, or garbage in the upper result bits. A long burst of mixed back-to-back operations checks the fixed four-cycle latency against a reference model.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_MUL    = 3'b000,
        OP_RDMODE = 3'b001,
        OP_MAC    = 3'b010,
        OP_MSU    = 3'b011,
        OP_WRACC  = 3'b100,
        OP_CLRACC = 3'b101,
        OP_RDACC  = 3'b110,
        OP_WRMODE = 3'b111
    } mac_op_e;

    typedef enum logic [1:0] {
        FMT_SIGNED   = 2'b00,
        FMT_UNSIGNED = 2'b01,
        FMT_FRAC     = 2'b10,
        FMT_RSVD     = 2'b11
    } mac_fmt_e;

endpackage

// File: rtl/mac_operand.sv
// Extends one raw operand to a signed value one bit wider than the data path.
module mac_operand
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              half,
    input  mac_fmt_e          fmt,
    output logic [DATA_W:0]   ext
);
    localparam int PAD = DATA_W - HALF_W;

    logic [HALF_W-1:0] lo;
    assign lo = raw[HALF_W-1:0];

    always_comb begin
        case (fmt)
            FMT_FRAC:
                // a short fraction occupies the top half of the word
                ext = half ? {lo[HALF_W-1], lo, {PAD{1'b0}}} : {raw[DATA_W-1], raw};
            FMT_UNSIGNED:
                ext = half ? {{(PAD+1){1'b0}}, lo} : {1'b0, raw};
            default:
                ext = half ? {{(PAD+1){lo[HALF_W-1]}}, lo} : {raw[DATA_W-1], raw};
        endcase
    end
endmodule

// File: rtl/mac_scaler.sv
// Turns a raw product into the accumulate addend and the plain-multiply result.
module mac_scaler
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 48
) (
    input  logic [2*DATA_W+1:0] prod,
    input  mac_fmt_e            fmt,
    output logic [2*DATA_W+1:0] addend,
    output logic [DATA_W-1:0]   mres
);
    localparam int PROD_W = 2*DATA_W + 2;
    localparam int FULL_W = 2*DATA_W;
    localparam int SHIFT  = FULL_W - ACC_W;
    localparam int EXT    = PROD_W - ACC_W;
    localparam logic [PROD_W-1:0] ONE_SQ = PROD_W'(1) << (FULL_W - 2);

    logic              clip;
    logic [FULL_W-1:0] q;

    always_comb begin
        // only (-1)*(-1) reaches 2^(FULL_W-2); doubling it would overflow
        clip = (prod == ONE_SQ);
        q    = clip ? {1'b0, {(FULL_W-1){1'b1}}} : {prod[FULL_W-2:0], 1'b0};
        if (fmt == FMT_FRAC) begin
            addend = {{EXT{q[FULL_W-1]}}, q[FULL_W-1:SHIFT]};
            mres   = q[FULL_W-1:DATA_W];
        end else begin
            addend = prod;
            mres   = prod[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/mac_accum.sv
// Adds or subtracts the addend and applies the range rule of the format.
module mac_accum
    import mac_pkg::*;
#(
    parameter int ACC_W  = 48,
    parameter int PROD_W = 66
) (
    input  logic [ACC_W-1:0]  acc,
    input  logic [PROD_W-1:0] addend,
    input  logic              sub,
    input  mac_fmt_e          fmt,
    input  logic              sat,
    output logic [ACC_W-1:0]  nxt,
    output logic              ovf
);
    localparam int SUM_W = PROD_W + 1;

    logic             uns;
    logic [SUM_W-1:0] acc_x;
    logic [SUM_W-1:0] add_x;
    logic [SUM_W-1:0] sum;
    logic [ACC_W-1:0] clamp;

    always_comb begin
        uns   = (fmt == FMT_UNSIGNED);
        acc_x = {{(SUM_W-ACC_W){acc[ACC_W-1] & ~uns}}, acc};
        add_x = {addend[PROD_W-1], addend};
        sum   = sub ? (acc_x - add_x) : (acc_x + add_x);
        if (uns) begin
            ovf   = |sum[SUM_W-1:ACC_W];
            clamp = sum[SUM_W-1] ? '0 : '1;
        end else begin
            ovf   = !((&sum[SUM_W-1:ACC_W-1]) || (~|sum[SUM_W-1:ACC_W-1]));
            clamp = sum[SUM_W-1] ? {1'b1, {(ACC_W-1){1'b0}}} : {1'b0, {(ACC_W-1){1'b1}}};
        end
        nxt = (ovf && sat) ? clamp : sum[ACC_W-1:0];
    end
endmodule

// File: rtl/mac_unit.sv
// Four-stage multiply-accumulate unit: operand prep, multiply, scale, accumulate.
module mac_unit
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HALF_W = 16,
    parameter int ACC_W  = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic              in_half,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [ACC_W-1:0]  out_data,
    output logic              out_ovf
);
    localparam int OPND_W = DATA_W + 1;
    localparam int PROD_W = 2*DATA_W + 2;
    localparam int WR_HI  = ACC_W - DATA_W;

    typedef struct packed {
        logic              vld;
        mac_op_e           op;
        mac_fmt_e          fmt;
        logic              sat;
        logic [OPND_W-1:0] a;
        logic [OPND_W-1:0] b;
        logic [ACC_W-1:0]  wr;
    } st1_t;

    typedef struct packed {
        logic              vld;
        mac_op_e           op;
        mac_fmt_e          fmt;
        logic              sat;
        logic [PROD_W-1:0] prod;
        logic [ACC_W-1:0]  wr;
    } st2_t;

    typedef struct packed {
        logic              vld;
        mac_op_e           op;
        mac_fmt_e          fmt;
        logic              sat;
        logic [PROD_W-1:0] addend;
        logic [DATA_W-1:0] mres;
        logic [ACC_W-1:0]  wr;
    } st3_t;

    typedef struct packed {
        st1_t             s1;
        st2_t             s2;
        st3_t             s3;
        logic             ovld;
        logic [ACC_W-1:0] odata;
        logic [ACC_W-1:0] acc;
        logic             ovf;
        logic             sat;
        mac_fmt_e         fmt;
    } state_t;

    state_t state_d, state_q;

    mac_op_e           op_in;
    logic              wr_mode;
    logic              eff_sat;
    mac_fmt_e          eff_fmt;
    logic [OPND_W-1:0] opnd_a, opnd_b;
    logic [PROD_W-1:0] addend;
    logic [DATA_W-1:0] mres;
    logic [ACC_W-1:0]  acc_nxt;
    logic              acc_ovf;

    // mode writes act at issue so the very next operation sees them
    assign op_in   = mac_op_e'(in_op);
    assign wr_mode = in_valid && (op_in == OP_WRMODE);
    assign eff_sat = wr_mode ? in_a[2] : state_q.sat;
    assign eff_fmt = wr_mode ? mac_fmt_e'(in_a[1:0]) : state_q.fmt;

    mac_operand #(.DATA_W(DATA_W), .HALF_W(HALF_W)) i_prep_a (
        .raw (in_a),
        .half(in_half),
        .fmt (eff_fmt),
        .ext (opnd_a)
    );

    mac_operand #(.DATA_W(DATA_W), .HALF_W(HALF_W)) i_prep_b (
        .raw (in_b),
        .half(in_half),
        .fmt (eff_fmt),
        .ext (opnd_b)
    );

    mac_scaler #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_scale (
        .prod  (state_q.s2.prod),
        .fmt   (state_q.s2.fmt),
        .addend(addend),
        .mres  (mres)
    );

    mac_accum #(.ACC_W(ACC_W), .PROD_W(PROD_W)) i_accum (
        .acc   (state_q.acc),
        .addend(state_q.s3.addend),
        .sub   (state_q.s3.op == OP_MSU),
        .fmt   (state_q.s3.fmt),
        .sat   (state_q.s3.sat),
        .nxt   (acc_nxt),
        .ovf   (acc_ovf)
    );

    always_comb begin
        state_d = state_q;

        state_d.sat = eff_sat;
        state_d.fmt = eff_fmt;

        // stage 1: register prepared operands
        state_d.s1.vld = in_valid;
        state_d.s1.op  = op_in;
        state_d.s1.fmt = eff_fmt;
        state_d.s1.sat = eff_sat;
        state_d.s1.a   = opnd_a;
        state_d.s1.b   = opnd_b;
        state_d.s1.wr  = {in_b[WR_HI-1:0], in_a};

        // stage 2: full-width signed multiply
        state_d.s2.vld  = state_q.s1.vld;
        state_d.s2.op   = state_q.s1.op;
        state_d.s2.fmt  = state_q.s1.fmt;
        state_d.s2.sat  = state_q.s1.sat;
        state_d.s2.prod = PROD_W'($signed(state_q.s1.a)) * PROD_W'($signed(state_q.s1.b));
        state_d.s2.wr   = state_q.s1.wr;

        // stage 3: fractional scaling
        state_d.s3.vld    = state_q.s2.vld;
        state_d.s3.op     = state_q.s2.op;
        state_d.s3.fmt    = state_q.s2.fmt;
        state_d.s3.sat    = state_q.s2.sat;
        state_d.s3.addend = addend;
        state_d.s3.mres   = mres;
        state_d.s3.wr     = state_q.s2.wr;

        // stage 4: accumulator and result
        state_d.ovld  = state_q.s3.vld;
        state_d.odata = '0;
        if (state_q.s3.vld) begin
            case (state_q.s3.op)
                OP_MUL: state_d.odata = {{WR_HI{1'b0}}, state_q.s3.mres};
                OP_MAC, OP_MSU: begin
                    state_d.acc   = acc_nxt;
                    state_d.ovf   = state_q.ovf | acc_ovf;
                    state_d.odata = acc_nxt;
                end
                OP_WRACC: begin
                    state_d.acc   = state_q.s3.wr;
                    state_d.odata = state_q.s3.wr;
                end
                OP_CLRACC: begin
                    state_d.acc = '0;
                    state_d.ovf = 1'b0;
                end
                OP_RDACC: state_d.odata = state_q.acc;
                default:
                    state_d.odata = ACC_W'({state_q.ovf, state_q.s3.sat, state_q.s3.fmt});
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.ovld;
    assign out_data  = state_q.odata;
    assign out_ovf   = state_q.ovf;

endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk
    import mac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [2:0]       in_op,
    input logic             out_valid,
    input logic [ACC_W-1:0] out_data,
    input logic             out_ovf
);
    p_issue_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##4 out_valid);

    p_no_phantom_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##4 !out_valid);

    p_mul_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_MUL) |-> ##4 (out_data[ACC_W-1:DATA_W] == '0));

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ovf && !$past(in_valid && in_op == OP_CLRACC, 3)) |=> out_ovf);

    p_clear_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_CLRACC) |-> ##4 (out_data == '0 && !out_ovf));

    p_mode_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_op == OP_RDMODE || in_op == OP_WRMODE))
            |-> ##4 (out_data[ACC_W-1:4] == '0));

    p_reset_idle_r8: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !out_ovf));

endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_op    (in_op),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_ovf  (out_ovf)
);

// File: tb/test_mac_unit.sv
module test_mac_unit;
    localparam int CLK_PERIOD = 10;

    localparam logic [2:0] K_MUL = 3'b000, K_RDMODE = 3'b001, K_MAC = 3'b010, K_MSU = 3'b011,
                           K_WRACC = 3'b100, K_CLR = 3'b101, K_RDACC = 3'b110, K_WRMODE = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_op = '0;
    logic        in_half = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [47:0] out_data;
    logic        out_ovf;

    mac_unit i_mac_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_half(in_half),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [47:0] data;
        bit          ovf;
        int          due;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   nchk = 0;
    int   nerr = 0;
    int   cyc  = 0;
    bit   done = 1'b0;

    logic [47:0] m_acc = '0;
    bit          m_ovf = 1'b0;
    bit          m_sat = 1'b0;
    logic [1:0]  m_fmt = 2'b00;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic signed [127:0] opnd(logic [31:0] x, bit half, logic [1:0] fmt);
        if (fmt == 2'b10) return half ? 128'($signed({x[15:0], 16'h0000})) : 128'($signed(x));
        if (fmt == 2'b01) return half ? 128'(x[15:0]) : 128'(x);
        return half ? 128'($signed(x[15:0])) : 128'($signed(x));
    endfunction

    // reference model, applied in issue order
    function automatic logic [47:0] model(logic [2:0] op, bit half, logic [31:0] a, logic [31:0] b);
        logic signed [127:0] p, s, c, accx, sum, lo, hi;
        logic [31:0] mres;
        logic [47:0] e;
        bit uns;
        if (op == K_WRMODE) begin
            m_sat = a[2];
            m_fmt = a[1:0];
        end
        uns = (m_fmt == 2'b01);
        p = opnd(a, half, m_fmt) * opnd(b, half, m_fmt);
        if (m_fmt == 2'b10) begin
            s = p * 2;
            if (s > 128'sh7FFF_FFFF_FFFF_FFFF) s = 128'sh7FFF_FFFF_FFFF_FFFF;
            c = s >>> 16;
            mres = s[63:32];
        end else begin
            c = p;
            mres = p[31:0];
        end
        e = '0;
        case (op)
            K_MUL: e = {16'h0000, mres};
            K_MAC, K_MSU: begin
                accx = uns ? 128'(m_acc) : 128'($signed(m_acc));
                sum  = (op == K_MSU) ? accx - c : accx + c;
                lo   = uns ? 128'sd0 : -(128'sd1 <<< 47);
                hi   = uns ? (128'sd1 <<< 48) - 1 : (128'sd1 <<< 47) - 1;
                if (sum < lo || sum > hi) begin
                    m_ovf = 1'b1;
                    if (m_sat) m_acc = (sum < lo) ? lo[47:0] : hi[47:0];
                    else       m_acc = sum[47:0];
                end else begin
                    m_acc = sum[47:0];
                end
                e = m_acc;
            end
            K_WRACC: begin m_acc = {b[15:0], a}; e = m_acc; end
            K_CLR:   begin m_acc = '0; m_ovf = 1'b0; e = '0; end
            K_RDACC: e = m_acc;
            default: e = {44'h0, m_ovf, m_sat, m_fmt};
        endcase
        return e;
    endfunction

    task automatic issue(input logic [2:0] op, input bit half, input logic [31:0] a,
                         input logic [31:0] b, input string tag);
        exp_t it;
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_half  = half;
        in_a     = a;
        in_b     = b;
        it.data  = model(op, half, a, b);
        it.ovf   = m_ovf;
        it.due   = cyc + 4;
        it.tag   = tag;
        sbq.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // monitor: compares each result beat with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && !done && out_valid) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R1 unexpected result", 64'(out_data), 64'h0);
            end else begin
                exp_t it;
                it = sbq.pop_front();
                check(out_data == it.data, {it.tag, " data"}, 64'(out_data), 64'(it.data));
                check(out_ovf == it.ovf, {it.tag, " ovf"}, 64'(out_ovf), 64'(it.ovf));
                check(cyc == it.due, "R1 latency", 64'(cyc), 64'(it.due));
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R8 valid in reset", 64'(out_valid), 64'h0);
        check(out_ovf == 1'b0, "R8 ovf in reset", 64'(out_ovf), 64'h0);
        rst_n = 1'b1;
        issue(K_RDACC, 0, 0, 0, "R8 acc after reset");
        issue(K_RDMODE, 0, 0, 0, "R8 mode after reset");

        // R2 plain multiplies in each integer format and width
        issue(K_MUL, 0, 32'hFFFF_FFFD, 32'd7, "R2 signed mul");
        issue(K_MUL, 1, 32'h1234_FFFE, 32'h0000_0005, "R2 half signed mul");
        issue(K_WRMODE, 0, 32'd1, 0, "R7 set unsigned");
        issue(K_MUL, 0, 32'hFFFF_FFFF, 32'd2, "R2 unsigned mul");
        issue(K_MUL, 1, 32'hABCD_FFFF, 32'h0000_FFFF, "R2 half unsigned mul");
        issue(K_WRMODE, 0, 32'd0, 0, "R7 set signed");

        // R3 dependent accumulates back to back
        issue(K_CLR, 0, 0, 0, "R6 clear");
        issue(K_MAC, 0, 32'd100, 32'd3, "R3 mac");
        issue(K_MAC, 0, 32'hFFFF_FFF6, 32'd4, "R3 mac neg");
        issue(K_MSU, 0, 32'd5, 32'd5, "R3 msu");
        issue(K_MSU, 1, 32'h0000_8000, 32'h0000_0002, "R3 half msu");
        idle(2);

        // R6 ordering of load/clear against in-flight accumulates
        issue(K_MAC, 0, 32'd9, 32'd9, "R6 mac before load");
        issue(K_WRACC, 0, 32'h0000_1000, 32'h0000_0001, "R6 load");
        issue(K_MAC, 0, 32'd1, 32'd1, "R6 mac after load");
        issue(K_CLR, 0, 0, 0, "R6 clear after mac");
        issue(K_MAC, 0, 32'd2, 32'd3, "R6 mac after clear");
        issue(K_RDACC, 0, 0, 0, "R6 read");

        // R4 fractional
        issue(K_WRMODE, 0, 32'd2, 0, "R7 set frac");
        issue(K_MUL, 0, 32'h4000_0000, 32'h4000_0000, "R4 frac quarter");
        issue(K_MUL, 0, 32'h8000_0000, 32'h8000_0000, "R4 frac minus one squared");
        issue(K_CLR, 0, 0, 0, "R6 clear");
        issue(K_MAC, 0, 32'h8000_0000, 32'h8000_0000, "R4 frac mac clamp");
        issue(K_MSU, 1, 32'h0000_4000, 32'h0000_C000, "R4 half frac msu");
        issue(K_MUL, 1, 32'h0000_8000, 32'h0000_8000, "R4 half frac minus one");
        issue(K_RDMODE, 0, 0, 0, "R7 read frac mode");

        // R5 signed wrap then saturate
        issue(K_WRMODE, 0, 32'd0, 0, "R7 signed wrap");
        issue(K_WRACC, 0, 32'hFFFF_FFFF, 32'h0000_7FFF, "R5 load max");
        issue(K_MAC, 0, 32'd1, 32'd1, "R5 wrap overflow");
        issue(K_MUL, 0, 32'd3, 32'd3, "R5 sticky after mul");
        issue(K_RDMODE, 0, 0, 0, "R7 read with ovf");
        issue(K_CLR, 0, 0, 0, "R6 clear drops ovf");
        issue(K_WRMODE, 0, 32'd4, 0, "R7 signed sat");
        issue(K_WRACC, 0, 32'hFFFF_FFFF, 32'h0000_7FFF, "R5 load max");
        issue(K_MAC, 0, 32'd1, 32'd1, "R5 sat high");
        issue(K_WRACC, 0, 32'h0000_0000, 32'h0000_8000, "R5 load min");
        issue(K_MSU, 0, 32'd1, 32'd1, "R5 sat low");

        // R9 unsigned limits
        issue(K_CLR, 0, 0, 0, "R6 clear");
        issue(K_WRMODE, 0, 32'd1, 0, "R7 unsigned wrap");
        issue(K_MSU, 0, 32'd1, 32'd1, "R9 unsigned wrap below");
        issue(K_CLR, 0, 0, 0, "R6 clear");
        issue(K_WRMODE, 0, 32'd5, 0, "R7 unsigned sat");
        issue(K_MSU, 0, 32'd1, 32'd1, "R9 unsigned clamp zero");
        issue(K_WRACC, 0, 32'hFFFF_FFF0, 32'h0000_FFFF, "R9 load near top");
        issue(K_MAC, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 unsigned clamp top");
        idle(6);

        // R1 mixed back-to-back burst against the model
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            logic [2:0]  rop;
            ra  = $urandom();
            rb  = $urandom();
            rop = 3'($urandom_range(0, 7));
            if (($urandom() & 7) == 0) ra = 32'h8000_0000;
            if (($urandom() & 7) == 0) rb = 32'hFFFF_FFFF;
            issue(rop, bit'($urandom() & 1), ra, rb, "R1 burst");
            if (($urandom() & 15) == 0) idle(1);
        end
        idle(10);
        check(sbq.size() == 0, "R1 results drained", 64'(sbq.size()), 64'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule